// File: doc/BRIEF.md
# Host-Target Mailbox Interface

This block is a small memory-mapped mailbox that lets a target processor pass commands to a host. It holds two wide registers, one toward the host and one from the host. Software reaches both through a word-wide register port. Each register spans several consecutive word slots, and a write changes only the word it addresses.

Writing the most significant word of the to-host register commits a command. The full to-host value after that write is decoded by two fields: the device in the top byte and the command in the byte below it. Three commands are handled:

- **Power-off**: the whole value equals one. It raises a sticky halt output.
- **Console output**: device 1, command 1. It sends the low byte out on a valid/ready stream. Once the byte is taken, the block clears the to-host register and writes an acknowledgment into the from-host register.
- **Keyboard-interrupt request**: device 1, command 0. It clears the to-host register.

Any other committed value stays in the registers and produces a one-cycle unsupported-command pulse.

Top module: `hostlink_mbox`

## Requirements
- R1: After reset both registers read zero and `con_valid`, `halt` and `bad_cmd` are low.
- R2: With the default parameters the to-host register occupies byte offsets 0 (bits 31:0) and 4 (bits 63:32), and the from-host register occupies offsets 8 (bits 31:0) and 12 (bits 63:32). A write replaces only the 32 bits of the addressed word.
- R3: `bus_rdata` combinationally returns the word at `bus_raddr`. Offsets 16 to 31, and any offset whose two low bits are not zero, read as zero.
- R4: Writes to undefined or misaligned offsets change no register. A write to offset 0 never commits a command.
- R5: A committed to-host value exactly equal to 1 sets `halt` on the next clock edge. `halt` then stays high until reset, and the to-host register keeps the value 1.
- R6: A committed value with device (bits 63:56) equal to 1 and command (bits 55:48) equal to 1 raises `con_valid` one cycle after the commit, with `con_byte` equal to to-host bits 7:0.
- R7: On the edge where `con_valid` and `con_ready` are both high, the to-host register becomes zero. On the same edge the from-host register becomes the committed device in bits 63:56, the committed command in bits 55:48, and zero elsewhere.
- R8: While `con_valid` is high and `con_ready` is low, `con_valid` and `con_byte` hold, the to-host register is not cleared, and writes to the to-host words are dropped.
- R9: A committed value with device 1 and command 0 clears the to-host register on the commit edge, leaves the from-host register unchanged, and emits no byte.
- R10: Any other committed value stays in the to-host register as written. `bad_cmd` is high for exactly the one cycle after the commit edge, and a later command does not lower `halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one word |
| bus_addr | input | 5 | Byte offset of the write |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 5 | Byte offset of the read |
| bus_rdata | output | 32 | Read data, combinational |
| con_valid | output | 1 | Console byte available |
| con_ready | input | 1 | Console sink accepts the byte |
| con_byte | output | 8 | Console byte |
| halt | output | 1 | Sticky power-off indication |
| bad_cmd | output | 1 | One-cycle pulse for an unsupported command |

## Verification
The assertions assume that the write strobe, address and data are stable around each rising edge. They also assume that `con_ready` is an ordinary level that may change at any cycle, including while a byte is waiting. The stimulus changes every input only on the falling clock edge and reads outputs just after that edge. It holds `con_ready` low across several cycles and across a dropped write to cover the stall, then raises it. A second byte is sent with the sink already ready, so the accept follows the commit in the very next cycle.

// File: rtl/hlm_pkg.sv
package hlm_pkg;
   typedef enum logic [1:0] {
      HK_OFF   = 2'd0,
      HK_PUTC  = 2'd1,
      HK_KBD   = 2'd2,
      HK_OTHER = 2'd3
   } hlm_kind_e;
endpackage

// File: rtl/hlm_decode.sv
module hlm_decode
   import hlm_pkg::*;
#(
   parameter int          REG_W    = 64,
   parameter int          FIELD_W  = 8,
   parameter logic [7:0]  DEV_CON  = 8'd1,
   parameter logic [7:0]  CMD_PUTC = 8'd1,
   parameter logic [7:0]  CMD_KBD  = 8'd0
) (
   input  logic [REG_W-1:0] value,
   output hlm_kind_e        kind
);
   localparam int DEV_HI = REG_W - 1;
   localparam int CMD_HI = REG_W - 1 - FIELD_W;

   logic [FIELD_W-1:0] dev_f, cmd_f;
   logic               is_con;

   assign dev_f  = value[DEV_HI -: FIELD_W];
   assign cmd_f  = value[CMD_HI -: FIELD_W];
   assign is_con = (dev_f == FIELD_W'(DEV_CON));

   always_comb begin
      if (value == REG_W'(1))
         kind = HK_OFF;
      else if (is_con && cmd_f == FIELD_W'(CMD_PUTC))
         kind = HK_PUTC;
      else if (is_con && cmd_f == FIELD_W'(CMD_KBD))
         kind = HK_KBD;
      else
         kind = HK_OTHER;
   end
endmodule

// File: rtl/hlm_regs.sv
module hlm_regs #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int REG_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              block_th,
   input  logic              clr_th,
   input  logic              ack_ld,
   input  logic [REG_W-1:0]  ack_val,
   output logic [REG_W-1:0]  tohost_q,
   output logic [REG_W-1:0]  fromhost_q,
   output logic              commit,
   output logic [REG_W-1:0]  commit_val
);
   localparam int NW    = REG_W / DATA_W;
   localparam int NSLOT = 2 * NW;
   localparam int IX_W  = ADDR_W - 2;

   if (REG_W % DATA_W != 0) begin : g_bad_ratio
      $error("REG_W must be a multiple of DATA_W");
   end
   if (NSLOT > (1 << IX_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for both registers");
   end

   logic [IX_W-1:0]  wr_ix, rd_ix;
   logic             wr_al, rd_al;
   logic [NW-1:0]    th_hit, fh_hit;
   logic [REG_W-1:0] th_merge, fh_merge;
   logic [DATA_W-1:0] slot [NSLOT];

   assign wr_ix = wr_addr[ADDR_W-1:2];
   assign rd_ix = rd_addr[ADDR_W-1:2];
   assign wr_al = (wr_addr[1:0] == 2'b00);
   assign rd_al = (rd_addr[1:0] == 2'b00);

   for (genvar g = 0; g < NW; g++) begin : g_word
      assign th_hit[g] = wr_en && wr_al && !block_th && (wr_ix == IX_W'(g));
      assign fh_hit[g] = wr_en && wr_al && (wr_ix == IX_W'(NW + g));
      assign slot[g]      = tohost_q[g*DATA_W +: DATA_W];
      assign slot[NW + g] = fromhost_q[g*DATA_W +: DATA_W];
   end

   always_comb begin
      th_merge = tohost_q;
      fh_merge = fromhost_q;
      for (int k = 0; k < NW; k++) begin
         if (th_hit[k]) th_merge[k*DATA_W +: DATA_W] = wr_data;
         if (fh_hit[k]) fh_merge[k*DATA_W +: DATA_W] = wr_data;
      end
   end

   assign commit     = th_hit[NW-1];
   assign commit_val = th_merge;

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NSLOT; k++)
         if (rd_al && rd_ix == IX_W'(k)) rd_data = slot[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tohost_q   <= '0;
         fromhost_q <= '0;
      end else begin
         tohost_q   <= clr_th ? '0 : th_merge;
         fromhost_q <= ack_ld ? ack_val : fh_merge;
      end
   end

   // R8: to-host frozen while a byte waits and is not taken
   a_r8_tohost_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (block_th && !clr_th) |=> $stable(tohost_q));
   // R4: a misaligned write leaves both registers alone
   a_r4_misaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_al && !clr_th && !ack_ld) |=> ($stable(tohost_q) && $stable(fromhost_q)));
endmodule

// File: rtl/hlm_console.sv
module hlm_console #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              ready,
   output logic              valid,
   output logic [BYTE_W-1:0] byte_o,
   output logic              accept
);
   logic              pend_q;
   logic [BYTE_W-1:0] byte_q;

   assign valid  = pend_q;
   assign byte_o = byte_q;
   assign accept = pend_q && ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         byte_q <= '0;
      end else if (load) begin
         pend_q <= 1'b1;
         byte_q <= load_byte;
      end else if (accept) begin
         pend_q <= 1'b0;
      end
   end

   // R8: stalled byte holds
   a_r8_hold_stream: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(byte_o)));
   // R6: load is seen one cycle later
   a_r6_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (valid && byte_o == $past(load_byte)));
endmodule

// File: rtl/hostlink_mbox.sv
module hostlink_mbox
   import hlm_pkg::*;
#(
   parameter int         ADDR_W   = 5,
   parameter int         DATA_W   = 32,
   parameter int         REG_W    = 64,
   parameter int         FIELD_W  = 8,
   parameter logic [7:0] DEV_CON  = 8'd1,
   parameter logic [7:0] CMD_PUTC = 8'd1,
   parameter logic [7:0] CMD_KBD  = 8'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [ADDR_W-1:0] bus_raddr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              con_valid,
   input  logic              con_ready,
   output logic [7:0]        con_byte,
   output logic              halt,
   output logic              bad_cmd
);
   localparam int TAG_W = 2 * FIELD_W;

   if (DATA_W < 8 || TAG_W > REG_W) begin : g_bad_width
      $error("register too narrow for byte and command fields");
   end

   logic             commit, accept, clr_th, putc_go;
   logic [REG_W-1:0] tohost_q, fromhost_q, commit_val, ack_val;
   hlm_kind_e        kind;

   hlm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
      .rd_addr(bus_raddr), .rd_data(bus_rdata),
      .block_th(con_valid), .clr_th(clr_th),
      .ack_ld(accept), .ack_val(ack_val),
      .tohost_q(tohost_q), .fromhost_q(fromhost_q),
      .commit(commit), .commit_val(commit_val)
   );

   hlm_decode #(.REG_W(REG_W), .FIELD_W(FIELD_W), .DEV_CON(DEV_CON),
                .CMD_PUTC(CMD_PUTC), .CMD_KBD(CMD_KBD)) u_dec (
      .value(commit_val), .kind(kind)
   );

   hlm_console #(.BYTE_W(8)) u_con (
      .clk(clk), .rst_n(rst_n),
      .load(putc_go), .load_byte(commit_val[7:0]),
      .ready(con_ready), .valid(con_valid), .byte_o(con_byte),
      .accept(accept)
   );

   assign putc_go = commit && (kind == HK_PUTC);
   assign clr_th  = accept || (commit && kind == HK_KBD);
   assign ack_val = {tohost_q[REG_W-1 -: TAG_W], {(REG_W-TAG_W){1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt    <= 1'b0;
         bad_cmd <= 1'b0;
      end else begin
         if (commit && kind == HK_OFF) halt <= 1'b1;
         bad_cmd <= commit && (kind == HK_OTHER);
      end
   end

   // R5: halt never drops once set
   a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt);
   // R10: the unsupported pulse always follows a commit
   a_r10_bad_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
      bad_cmd |-> $past(commit));
   // R7: acknowledgment echoes device and command, to-host cleared
   a_r7_ack_echo: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (tohost_q == '0 &&
                  fromhost_q[REG_W-1 -: TAG_W] == $past(tohost_q[REG_W-1 -: TAG_W]) &&
                  fromhost_q[REG_W-TAG_W-1:0] == '0));
endmodule

// File: tb/hostlink_mbox_test.sv
`timescale 1ns/1ps
module hostlink_mbox_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [4:0]  bus_raddr = '0;
   logic [31:0] bus_rdata;
   logic        con_valid, con_ready = 1'b0;
   logic [7:0]  con_byte;
   logic        halt, bad_cmd;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   hostlink_mbox uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
      .con_valid(con_valid), .con_ready(con_ready), .con_byte(con_byte),
      .halt(halt), .bad_cmd(bad_cmd)
   );

   // {write addr, write data, read addr, expected read}
   localparam logic [73:0] TBL [8] = '{
      {5'd8,  32'hA5A5_0001, 5'd8,  32'hA5A5_0001},  // R2
      {5'd12, 32'h1234_5678, 5'd8,  32'hA5A5_0001},  // R2 low kept
      {5'd20, 32'hFFFF_FFFF, 5'd12, 32'h1234_5678},  // R4 undefined write
      {5'd0,  32'h0000_00AB, 5'd0,  32'h0000_00AB},  // R2
      {5'd0,  32'h0000_0001, 5'd4,  32'h0000_0000},  // R4 no commit
      {5'd16, 32'h5555_5555, 5'd16, 32'h0000_0000},  // R3 undefined read
      {5'd8,  32'h0000_0000, 5'd12, 32'h1234_5678},  // R2 high kept
      {5'd13, 32'h0000_DEAD, 5'd12, 32'h1234_5678}   // R4 misaligned
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
      bus_raddr = a;
      #1;
      check(bus_rdata === exp, req, bus_rdata, exp);
   endtask

   task automatic bit_chk(input logic act, input logic exp, input string req);
      check(act === exp, req, {31'b0, act}, {31'b0, exp});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd_chk(5'd0,  32'h0, "R1 tohost lo");
      rd_chk(5'd4,  32'h0, "R1 tohost hi");
      rd_chk(5'd8,  32'h0, "R1 fromhost lo");
      rd_chk(5'd12, 32'h0, "R1 fromhost hi");
      bit_chk(con_valid, 1'b0, "R1 con_valid");
      bit_chk(halt, 1'b0, "R1 halt");
      bit_chk(bad_cmd, 1'b0, "R1 bad_cmd");

      for (int i = 0; i < 8; i++) begin
         wr(TBL[i][73:69], TBL[i][68:37]);
         rd_chk(TBL[i][36:32], TBL[i][31:0], "R2/R3/R4 table");
      end
      rd_chk(5'd1, 32'h0, "R3 misaligned read");
      bit_chk(halt, 1'b0, "R4 low write no power-off");
      bit_chk(bad_cmd, 1'b0, "R4 low write no commit");
      bit_chk(con_valid, 1'b0, "R4 no byte");

      // R10 unsupported command dev 2 cmd 3
      wr(5'd0, 32'h0000_0055);
      wr(5'd4, 32'h0203_0000);
      bit_chk(bad_cmd, 1'b1, "R10 pulse");
      rd_chk(5'd4, 32'h0203_0000, "R10 hi kept");
      rd_chk(5'd0, 32'h0000_0055, "R10 lo kept");
      @(negedge clk);
      bit_chk(bad_cmd, 1'b0, "R10 one cycle");

      // R9 keyboard request
      wr(5'd4, 32'h0100_0000);
      rd_chk(5'd0,  32'h0, "R9 tohost lo cleared");
      rd_chk(5'd4,  32'h0, "R9 tohost hi cleared");
      rd_chk(5'd12, 32'h1234_5678, "R9 fromhost unchanged");
      bit_chk(con_valid, 1'b0, "R9 no byte");
      bit_chk(bad_cmd, 1'b0, "R9 supported");

      // R6/R8/R7 console byte with stalled sink
      wr(5'd0, 32'h0000_0041);
      wr(5'd4, 32'h0101_0000);
      bit_chk(con_valid, 1'b1, "R6 valid");
      check(con_byte === 8'h41, "R6 byte", {24'b0, con_byte}, 32'h41);
      repeat (3) @(negedge clk);
      bit_chk(con_valid, 1'b1, "R8 valid held");
      check(con_byte === 8'h41, "R8 byte held", {24'b0, con_byte}, 32'h41);
      wr(5'd0, 32'h0000_0099);
      rd_chk(5'd0, 32'h0000_0041, "R8 write dropped");
      rd_chk(5'd4, 32'h0101_0000, "R8 not cleared");
      con_ready = 1'b1;
      @(negedge clk);
      bit_chk(con_valid, 1'b0, "R7 valid drops");
      rd_chk(5'd0,  32'h0, "R7 tohost lo");
      rd_chk(5'd4,  32'h0, "R7 tohost hi");
      rd_chk(5'd8,  32'h0, "R7 fromhost lo");
      rd_chk(5'd12, 32'h0101_0000, "R7 fromhost hi");

      // R6/R7 console byte with ready already high
      wr(5'd12, 32'h0);
      wr(5'd0, 32'h0000_005A);
      wr(5'd4, 32'h0101_0000);
      bit_chk(con_valid, 1'b1, "R6 valid ready-high");
      check(con_byte === 8'h5A, "R6 byte 5A", {24'b0, con_byte}, 32'h5A);
      @(negedge clk);
      bit_chk(con_valid, 1'b0, "R7 taken");
      rd_chk(5'd12, 32'h0101_0000, "R7 ack again");
      rd_chk(5'd0, 32'h0, "R7 cleared again");
      con_ready = 1'b0;

      // R5 power-off
      wr(5'd0, 32'h0000_0001);
      wr(5'd4, 32'h0000_0000);
      bit_chk(halt, 1'b1, "R5 halt");
      rd_chk(5'd0, 32'h1, "R5 tohost kept");
      bit_chk(bad_cmd, 1'b0, "R5 not unsupported");
      wr(5'd4, 32'h0203_0000);
      bit_chk(bad_cmd, 1'b1, "R10 later bad");
      bit_chk(halt, 1'b1, "R10 halt sticky");
      repeat (2) @(negedge clk);
      bit_chk(halt, 1'b1, "R5 halt sticky");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule